// File: doc/BRIEF.md
# Sensorless Six-Step Commutation Sequencer

This block sequences the three half-bridges of a brushless motor that has no position sensors. It runs through six drive steps per electrical revolution. In each step one phase sources current, one sinks it, and the third floats. An external comparator reports whether the floating phase sits above the motor's centre tap. The block uses that single bit to find back-EMF zero crossings and to time commutation from them.

After enable, the sequencer starts in step 1. It advances blindly on pulses from a free-running start-up oscillator. During this phase it watches the floating phase for a crossing whose direction suits the current step and the selected rotation. The first such crossing hands control to back-EMF timing. From then on, each accepted crossing toggles a flag and starts a wait of half the last crossing-to-crossing interval, and the sequencer then moves one step. If no crossing arrives within a limit, the block returns to blind stepping from step 1.

A brake request, from either a pin or a configuration bit, turns on all three low sides. The same step table serves both rotation directions; only the visiting order changes.

Top module: `sixstep_seq`

## Requirements
- R1: While reset is active, and after it is released with enable low, all drive codes are off (00) and locked and zc_toggle are 0. The first clock edge with enable high starts step 1.
- R2: Drive codes are 00 off, 01 high, 10 low. The high and low phases for each step are: step 1 A/B, step 2 A/C, step 3 B/C, step 4 B/A, step 5 C/A, step 6 C/B. The remaining phase is off, and float_sel names it (0=A, 1=B, 2=C).
- R3: With dir_rev=0 the steps follow the order 1,2,3,4,5,6,1. With dir_rev=1 they follow the order 1,6,5,4,3,2,1.
- R4: While not locked, each clock edge that samples start_tick high advances the sequence by one step.
- R5: A crossing is a change of bemf_above between two edges. Only a crossing in the expected direction is accepted: rising (0 to 1) in odd steps and falling in even steps when dir_rev=0, and the opposite when dir_rev=1. Any other change leaves zc_toggle and locked unchanged.
- R6: An accepted crossing inverts zc_toggle and sets locked at that edge. While locked, start_tick has no effect.
- R7: An interval counter restarts at 1 on every accepted crossing and on every start-up step, and rises by one per edge. With N its value at an accepted crossing, the next step takes effect exactly floor(N/2)+1 edges after that crossing.
- R8: The first edge after any step change never accepts a crossing.
- R9: While locked and waiting for a crossing, if the interval counter reaches stall_limit the block clears locked and returns to blind stepping in step 1.
- R10: While brake_pin or brake_cfg is high, all three drive codes are low (10) at once. The next edge clears locked. After release, the next edge restarts in step 1 with locked clear.
- R11: Dropping enable turns all drives off at the next edge and clears locked. start_tick has no effect while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request |
| dir_rev | input | 1 | 0 forward, 1 reverse rotation |
| brake_pin | input | 1 | Brake request from the pin |
| brake_cfg | input | 1 | Brake request from configuration |
| start_tick | input | 1 | One-cycle pulse from the start-up oscillator |
| bemf_above | input | 1 | Floating phase above centre tap |
| stall_limit | input | CNT_W | Crossing timeout in clocks |
| drv_a | output | 2 | Phase A drive code |
| drv_b | output | 2 | Phase B drive code |
| drv_c | output | 2 | Phase C drive code |
| float_sel | output | 2 | Index of the floating phase |
| zc_toggle | output | 1 | Inverts on each accepted crossing |
| locked | output | 1 | Commutation timed from back-EMF |

## Verification
A wrong step register shows up on the three drive codes in the same cycle, as a high/low pair that breaks the table or skips the order. A broken polarity or blanking decision shows up at zc_toggle and locked at the very edge of the offending crossing. A wrong delay count moves the commutation edge by at least one clock, and the next crossing's interval then compounds that error. A faulty timeout leaves locked set past the edge at which the counter reaches the limit.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;

  typedef enum logic [1:0] {
    DRV_OFF  = 2'b00,
    DRV_HIGH = 2'b01,
    DRV_LOW  = 2'b10
  } drv_t;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_START = 2'd1,
    M_WAIT  = 2'd2,
    M_DELAY = 2'd3
  } mode_t;

  // phase sourcing current in a step (0=A, 1=B, 2=C)
  function automatic logic [1:0] src_phase(input logic [2:0] s);
    case (s)
      3'd1, 3'd2: return 2'd0;
      3'd3, 3'd4: return 2'd1;
      default:    return 2'd2;
    endcase
  endfunction

  // phase sinking current in a step
  function automatic logic [1:0] snk_phase(input logic [2:0] s);
    case (s)
      3'd1, 3'd6: return 2'd1;
      3'd2, 3'd3: return 2'd2;
      default:    return 2'd0;
    endcase
  endfunction

  function automatic logic [2:0] step_next(input logic [2:0] s, input logic rev);
    if (!rev) return (s == 3'd6) ? 3'd1 : s + 3'd1;
    else      return (s == 3'd1) ? 3'd6 : s - 3'd1;
  endfunction

  // rising crossing expected in odd steps going forward
  function automatic logic want_rise(input logic [2:0] s, input logic rev);
    return s[0] ^ rev;
  endfunction

endpackage

// File: rtl/sixstep_zc.sv
module sixstep_zc (
  input  logic clk,
  input  logic rst_n,
  input  logic bemf_above,
  input  logic rise_exp,
  input  logic arm,
  input  logic blank_req,
  output logic zc_ev
);
  logic bemf_q;
  logic blank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bemf_q  <= 1'b0;
      blank_q <= 1'b1;
    end else begin
      bemf_q  <= bemf_above;
      blank_q <= blank_req;
    end
  end

  assign zc_ev = arm && !blank_q && (bemf_above != bemf_q) && (bemf_above == rise_exp);
endmodule

// File: rtl/sixstep_timer.sv
module sixstep_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             load_dly,
  input  logic             run_dly,
  input  logic [CNT_W-1:0] limit,
  output logic             dly_done,
  output logic             stall_hit
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] since_q;
  logic [CNT_W-1:0] dly_q;

  function automatic logic [CNT_W-1:0] half_span(input logic [CNT_W-1:0] n);
    return n >> 1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      dly_q   <= '0;
    end else begin
      if (restart)                since_q <= CNT_ONE;
      else if (since_q != CNT_MAX) since_q <= since_q + CNT_ONE;

      if (load_dly)                      dly_q <= half_span(since_q);
      else if (run_dly && dly_q != '0)   dly_q <= dly_q - CNT_ONE;
    end
  end

  assign dly_done  = (dly_q == '0);
  assign stall_hit = (since_q >= limit);
endmodule

// File: rtl/sixstep_drive.sv
module sixstep_drive
  import sixstep_pkg::*;
(
  input  logic [2:0] step,
  input  logic       active,
  input  logic       brk,
  output logic [1:0] drv_a,
  output logic [1:0] drv_b,
  output logic [1:0] drv_c,
  output logic [1:0] float_sel
);
  logic [1:0] hi_p;
  logic [1:0] lo_p;
  logic [1:0] code [3];

  assign hi_p = src_phase(step);
  assign lo_p = snk_phase(step);

  for (genvar p = 0; p < 3; p++) begin : g_phase
    always_comb begin
      if (brk)                      code[p] = DRV_LOW;
      else if (!active)             code[p] = DRV_OFF;
      else if (hi_p == 2'(p))       code[p] = DRV_HIGH;
      else if (lo_p == 2'(p))       code[p] = DRV_LOW;
      else                          code[p] = DRV_OFF;
    end
  end

  assign drv_a     = code[0];
  assign drv_b     = code[1];
  assign drv_c     = code[2];
  assign float_sel = 2'd3 - hi_p - lo_p;
endmodule

// File: rtl/sixstep_seq.sv
module sixstep_seq
  import sixstep_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             dir_rev,
  input  logic             brake_pin,
  input  logic             brake_cfg,
  input  logic             start_tick,
  input  logic             bemf_above,
  input  logic [CNT_W-1:0] stall_limit,
  output logic [1:0]       drv_a,
  output logic [1:0]       drv_b,
  output logic [1:0]       drv_c,
  output logic [1:0]       float_sel,
  output logic             zc_toggle,
  output logic             locked
);
  mode_t      mode_q, mode_n;
  logic [2:0] step_q, step_n;
  logic       tog_q, tog_n;
  logic       brk;
  logic       zc_ev;
  logic       stall_hit;
  logic       dly_done;
  logic       restart;
  logic       load_dly;
  logic       step_chg;
  logic       arm;

  assign brk = brake_pin | brake_cfg;
  assign arm = (mode_q == M_START) || (mode_q == M_WAIT);

  sixstep_zc u_zc (
    .clk       (clk),
    .rst_n     (rst_n),
    .bemf_above(bemf_above),
    .rise_exp  (want_rise(step_q, dir_rev)),
    .arm       (arm),
    .blank_req (step_chg),
    .zc_ev     (zc_ev)
  );

  sixstep_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .load_dly (load_dly),
    .run_dly  (mode_q == M_DELAY),
    .limit    (stall_limit),
    .dly_done (dly_done),
    .stall_hit(stall_hit)
  );

  always_comb begin
    mode_n   = mode_q;
    step_n   = step_q;
    tog_n    = tog_q;
    restart  = 1'b0;
    load_dly = 1'b0;
    step_chg = 1'b0;
    if (brk || !enable) begin
      mode_n = M_IDLE;
      step_n = 3'd1;
    end else begin
      unique case (mode_q)
        M_IDLE: begin
          mode_n   = M_START;
          step_n   = 3'd1;
          restart  = 1'b1;
          step_chg = 1'b1;
        end
        M_START: begin
          if (zc_ev) begin
            tog_n    = ~tog_q;
            mode_n   = M_DELAY;
            load_dly = 1'b1;
            restart  = 1'b1;
          end else if (start_tick) begin
            step_n   = step_next(step_q, dir_rev);
            restart  = 1'b1;
            step_chg = 1'b1;
          end
        end
        M_WAIT: begin
          if (zc_ev) begin
            tog_n    = ~tog_q;
            mode_n   = M_DELAY;
            load_dly = 1'b1;
            restart  = 1'b1;
          end else if (stall_hit) begin
            mode_n   = M_START;
            step_n   = 3'd1;
            restart  = 1'b1;
            step_chg = 1'b1;
          end
        end
        M_DELAY: begin
          if (dly_done) begin
            step_n   = step_next(step_q, dir_rev);
            mode_n   = M_WAIT;
            step_chg = 1'b1;
          end
        end
        default: mode_n = M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_IDLE;
      step_q <= 3'd1;
      tog_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      step_q <= step_n;
      tog_q  <= tog_n;
    end
  end

  sixstep_drive u_drv (
    .step     (step_q),
    .active   (mode_q != M_IDLE),
    .brk      (brk),
    .drv_a    (drv_a),
    .drv_b    (drv_b),
    .drv_c    (drv_c),
    .float_sel(float_sel)
  );

  assign zc_toggle = tog_q;
  assign locked    = (mode_q == M_WAIT) || (mode_q == M_DELAY);
endmodule

// File: rtl/sixstep_chk.sv
module sixstep_chk
  import sixstep_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       dir_rev,
  input logic       brk,
  input logic [1:0] drv_a,
  input logic [1:0] drv_b,
  input logic [1:0] drv_c,
  input logic [1:0] float_sel,
  input logic       zc_toggle,
  input logic       locked,
  input logic       zc_ev,
  input logic       stall_hit,
  input logic [2:0] step
);
  logic [2:0] hi_vec;
  logic [2:0] lo_vec;
  logic [1:0] float_code;

  assign hi_vec = {drv_c == DRV_HIGH, drv_b == DRV_HIGH, drv_a == DRV_HIGH};
  assign lo_vec = {drv_c == DRV_LOW,  drv_b == DRV_LOW,  drv_a == DRV_LOW};
  assign float_code = (float_sel == 2'd0) ? drv_a : (float_sel == 2'd1) ? drv_b : drv_c;

  assert_brake_all_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> (drv_a == DRV_LOW && drv_b == DRV_LOW && drv_c == DRV_LOW));

  assert_one_src_one_snk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !brk) |-> ($countones(hi_vec) == 1 && $countones(lo_vec) == 1));

  assert_float_is_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !brk) |-> (float_code == DRV_OFF));

  assert_toggle_needs_crossing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_toggle != $past(zc_toggle)) |-> $past(zc_ev));

  assert_step_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step != $past(step) && step != 3'd1) |-> (step == step_next($past(step), $past(dir_rev))));

  assert_lock_drop_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(stall_hit || brk || !enable));
endmodule

bind sixstep_seq sixstep_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .dir_rev  (dir_rev),
  .brk      (brk),
  .drv_a    (drv_a),
  .drv_b    (drv_b),
  .drv_c    (drv_c),
  .float_sel(float_sel),
  .zc_toggle(zc_toggle),
  .locked   (locked),
  .zc_ev    (zc_ev),
  .stall_hit(stall_hit),
  .step     (step_q)
);

// File: tb/tb_sixstep_seq.sv
module tb_sixstep_seq;
  localparam int CW  = 16;
  localparam int LIM = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic dir_rev = 1'b0;
  logic brake_pin = 1'b0;
  logic brake_cfg = 1'b0;
  logic start_tick = 1'b0;
  logic bemf_above = 1'b0;
  logic [CW-1:0] stall_limit = CW'(LIM);
  logic [1:0] drv_a, drv_b, drv_c, float_sel;
  logic zc_toggle, locked;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sixstep_seq #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dir_rev(dir_rev),
    .brake_pin(brake_pin), .brake_cfg(brake_cfg), .start_tick(start_tick),
    .bemf_above(bemf_above), .stall_limit(stall_limit),
    .drv_a(drv_a), .drv_b(drv_b), .drv_c(drv_c), .float_sel(float_sel),
    .zc_toggle(zc_toggle), .locked(locked)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int hi_of(input int s);  return (s - 1) / 2;     endfunction
  function automatic int lo_of(input int s);  return (s / 2 + 1) % 3; endfunction
  function automatic int nxt(input int s, input bit rev);
    return rev ? ((s + 4) % 6) + 1 : (s % 6) + 1;
  endfunction
  function automatic bit pol(input int s, input bit rev);
    return ((s % 2) == 1) ^ rev;
  endfunction
  function automatic logic [5:0] exp_vec(input int s);
    logic [5:0] v = '0;
    v[2*hi_of(s) +: 2] = 2'b01;
    v[2*lo_of(s) +: 2] = 2'b10;
    return v;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_state(input int s, input string req);
    chk({drv_c, drv_b, drv_a} == exp_vec(s), req, "drive vector",
        int'({drv_c, drv_b, drv_a}), int'(exp_vec(s)));
    chk(int'(float_sel) == 3 - hi_of(s) - lo_of(s), req, "float_sel",
        int'(float_sel), 3 - hi_of(s) - lo_of(s));
  endtask

  task automatic run_dir(input bit rv);
    int s;
    int d;
    int n;
    int w;
    logic tg;
    dir_rev = rv;
    enable = 1'b1;
    tick();
    check_state(1, "R1 first step");
    chk(locked == 1'b0, "R1", "locked at start", int'(locked), 0);
    s = 1;
    // blind stepping sweep: R2 table, R3 order, R4 ticks, R5 wrong edges
    for (int k = 0; k < 6; k++) begin
      bemf_above = pol(s, rv);
      tg = zc_toggle;
      tick();                       // blanked edge after step change
      bemf_above = !pol(s, rv);
      tick();                       // wrong-direction crossing
      chk(zc_toggle == tg, "R5", "toggle after wrong edge", int'(zc_toggle), int'(tg));
      chk(locked == 1'b0, "R5", "locked after wrong edge", int'(locked), 0);
      check_state(s, "R2");
      start_tick = 1'b1;
      tick();
      start_tick = 1'b0;
      s = nxt(s, rv);
      check_state(s, "R3 R4 tick step");
    end
    // first accepted crossing in step 1
    bemf_above = !pol(s, rv);
    tick();
    bemf_above = pol(s, rv);
    tg = zc_toggle;
    tick();
    chk(zc_toggle == !tg, "R6", "toggle on lock", int'(zc_toggle), int'(!tg));
    chk(locked == 1'b1, "R6", "locked", int'(locked), 1);
    d = 1;
    for (int c = 0; c < 8; c++) begin
      for (int j = 1; j <= d; j++) begin
        if (j == 1) start_tick = 1'b1;
        tick();
        start_tick = 1'b0;
        check_state(s, "R7 R6 hold during delay");
      end
      tick();
      s = nxt(s, rv);
      check_state(s, "R7 commutation edge");
      chk(locked == 1'b1, "R7", "locked after commutation", int'(locked), 1);
      if (c == 2) begin
        bemf_above = pol(s, rv);
        tg = zc_toggle;
        tick();
        tick();
        chk(zc_toggle == tg, "R8", "toggle after blanked edge", int'(zc_toggle), int'(tg));
        check_state(s, "R8");
        bemf_above = !pol(s, rv);
        tick();
        bemf_above = pol(s, rv);
        tick();
        n = d + 5;
      end else begin
        w = 1 + (c * 7) % 11;
        tg = zc_toggle;
        repeat (w) tick();
        bemf_above = pol(s, rv);
        tick();
        n = d + w + 2;
      end
      chk(zc_toggle == !tg, "R6", "toggle on run crossing", int'(zc_toggle), int'(!tg));
      d = n / 2;
    end
    if (!rv) begin
      for (int j = 1; j <= d; j++) tick();
      tick();
      s = nxt(s, rv);
      check_state(s, "R7 last commutation");
      repeat (LIM - d - 2) tick();
      chk(locked == 1'b1, "R9", "locked before limit", int'(locked), 1);
      tick();
      chk(locked == 1'b0, "R9", "locked after limit", int'(locked), 0);
      check_state(1, "R9 fallback step");
      brake_pin = 1'b1;
      #1;
      chk({drv_c, drv_b, drv_a} == 6'b101010, "R10", "pin brake drive",
          int'({drv_c, drv_b, drv_a}), 42);
      tick();
      chk(locked == 1'b0, "R10", "locked under brake", int'(locked), 0);
      brake_pin = 1'b0;
      tick();
      check_state(1, "R10 restart");
    end else begin
      brake_cfg = 1'b1;
      #1;
      chk({drv_c, drv_b, drv_a} == 6'b101010, "R10", "cfg brake drive",
          int'({drv_c, drv_b, drv_a}), 42);
      tick();
      chk(locked == 1'b0, "R10", "locked under cfg brake", int'(locked), 0);
      brake_cfg = 1'b0;
      tick();
      check_state(1, "R10 restart");
      chk(locked == 1'b0, "R10", "locked after release", int'(locked), 0);
    end
    enable = 1'b0;
    tick();
    chk({drv_c, drv_b, drv_a} == 6'b0, "R11", "drive when disabled", int'({drv_c, drv_b, drv_a}), 0);
    chk(locked == 1'b0, "R11", "locked when disabled", int'(locked), 0);
    start_tick = 1'b1;
    tick();
    start_tick = 1'b0;
    chk({drv_c, drv_b, drv_a} == 6'b0, "R11", "tick while disabled", int'({drv_c, drv_b, drv_a}), 0);
  endtask

  initial begin
    repeat (3) tick();
    chk({drv_c, drv_b, drv_a} == 6'b0, "R1", "drive in reset", int'({drv_c, drv_b, drv_a}), 0);
    chk(locked == 1'b0, "R1", "locked in reset", int'(locked), 0);
    chk(zc_toggle == 1'b0, "R1", "toggle in reset", int'(zc_toggle), 0);
    rst_n = 1'b1;
    tick();
    tick();
    chk({drv_c, drv_b, drv_a} == 6'b0, "R1", "drive idle", int'({drv_c, drv_b, drv_a}), 0);
    for (int r = 0; r < 2; r++) run_dir(r[0]);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule